// File: doc/BRIEF.md
# SPI Command-Response Slave

This block is an SPI slave for a fixed, framed exchange of five bytes. An external master pulls chip select low and clocks eight command bits, then thirty-two more bits during which the slave answers. While the command byte comes in, the slave shifts out a preloaded filler byte. The received command goes out on a lookup port, and the 32-bit word that comes back is shifted out most significant bit first. It starts on the first clock of the second byte, with no idle bit.

The serial pins are sampled in the system clock domain, which must run at least eight times faster than SCK. The SPI mode is fixed: MOSI is taken on the rising SCK edge and MISO changes on the falling edge. Framing depends only on the chip-select pin. Releasing it at any point returns the counters and both shift registers to idle, so a partial or overlong frame cannot leave bytes behind that would shift the next answer. Two single-cycle strobes mark command capture and frame completion.

Top module: `spi_cmd_slave`

## Requirements
- R1: While chip select is high, MISO is 0 from the fourth system clock after the rising edge of chip select, and is also 0 during reset.
- R2: During the command byte, MISO carries the filler byte given by parameter DUMMY_BYTE (default 0xA5), most significant bit first. Its bit 7 is on MISO before the first rising SCK edge.
- R3: Bytes 2 to 5 carry the 32-bit answer most significant byte first, with bit 7 of each byte first. For an answer of 0x410547AF the bytes are 0x41, 0x05, 0x47, 0xAF. MOSI is sampled on the rising SCK edge and MISO changes after the falling edge.
- R4: After the eighth rising SCK edge, lut_cmd_o equals the received command byte, and the answer on lut_data_i is captured at the following falling SCK edge.
- R5: Any frame that starts after chip select has been high begins again with the filler byte and a correctly aligned answer, whatever the previous frame left unsent.
- R6: A frame released before its fortieth rising SCK edge produces no frame_done_o pulse.
- R7: cmd_valid_o pulses high for exactly one system clock, once per frame, after the eighth rising SCK edge, and cmd_o holds the command byte at that time.
- R8: frame_done_o pulses high for exactly one system clock, once per frame, after the fortieth rising SCK edge.
- R9: The MOSI value during bytes 2 to 5 has no effect on MISO.
- R10: SCK edges after the fortieth in the same frame raise no strobe, and MISO is 0 during those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | SPI serial clock from master, idle low |
| mosi_i | input | 1 | Serial data from master |
| cs_n_i | input | 1 | Active-low chip select from master |
| miso_o | output | 1 | Serial data to master, 0 when deselected |
| lut_cmd_o | output | 8 | Command byte presented to the answer lookup |
| lut_data_i | input | 32 | Answer word returned combinationally for lut_cmd_o |
| cmd_valid_o | output | 1 | One-cycle strobe: command byte received |
| cmd_o | output | 8 | Received command byte |
| frame_done_o | output | 1 | One-cycle strobe: full 40-bit frame received |

## Verification
A bit or byte counter that is wrong by even one count shows up within the same frame. The filler byte and the answer appear at shifted bit positions on MISO, and a strobe fires on the wrong bit or not at all. A transmit or receive register that is not cleared on chip-select release would only show up in the next frame, so frames are run back to back after partial and overlong frames. A lookup captured at the wrong moment gives a wrong answer word from the very first bit of byte 2.

// File: rtl/spi_cs_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes and types for the SPI command-response slave.
// Assumes a byte of a power-of-two width and a fixed response length.
package spi_cs_pkg;
    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned RESP_BYTES  = 4;
    localparam int unsigned FRAME_BYTES = RESP_BYTES + 1;
    localparam int unsigned RESP_W      = BYTE_W * RESP_BYTES;
    localparam int unsigned BIT_CNT_W   = $clog2(BYTE_W);
    localparam int unsigned BYTE_CNT_W  = $clog2(FRAME_BYTES + 1);

    typedef logic [BIT_CNT_W-1:0]  bit_cnt_t;
    typedef logic [BYTE_CNT_W-1:0] byte_cnt_t;

    // Serial events in the system clock domain
    typedef struct packed {
        logic active;   // chip select asserted (synchronized)
        logic rise;     // SCK rising edge seen this cycle
        logic fall;     // SCK falling edge seen this cycle
        logic mosi;     // synchronized MOSI, aligned with rise
    } spi_evt_t;
endpackage

// File: rtl/spi_cs_sync.sv
`timescale 1ns/1ps
// Module: spi_cs_sync
// Brings SCK, MOSI and CS_n into the system clock domain through a
// flop chain per pin and derives SCK edge events. Assumes STAGES >= 2,
// a system clock at least 8x SCK and SCK idle low (mode 0). Edges are
// reported only while chip select is asserted.
module spi_cs_sync
    import spi_cs_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sck_i,
    input  logic     mosi_i,
    input  logic     cs_n_i,
    output spi_evt_t evt_o
);
    localparam int unsigned NPINS  = 3;
    localparam int unsigned PIN_CS = 2;

    logic [NPINS-1:0] raw;
    logic [NPINS-1:0] synced;
    logic             sck_prev;

    assign raw = {cs_n_i, mosi_i, sck_i};

    genvar g;
    for (g = 0; g < NPINS; g++) begin : g_pin
        logic [STAGES-1:0] chain;
        // Shift the pin through its synchronizer chain; CS resets inactive
        always_ff @(posedge clk) begin
            if (!rst_n)
                chain <= (g == PIN_CS) ? {STAGES{1'b1}} : {STAGES{1'b0}};
            else
                chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    // Remember the previous synchronized SCK level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= synced[0];
    end

    // Form events; edges outside chip select are dropped
    always_comb begin
        evt_o.active = ~synced[PIN_CS];
        evt_o.rise   = evt_o.active & synced[0] & ~sck_prev;
        evt_o.fall   = evt_o.active & ~synced[0] & sck_prev;
        evt_o.mosi   = synced[1];
    end
endmodule

// File: rtl/spi_cs_frame.sv
`timescale 1ns/1ps
// Module: spi_cs_frame
// Counts bits and bytes within one chip-select window and flags the
// command boundary, the answer load point and frame completion.
// Assumes events from spi_cs_sync. Counters saturate after the last
// byte and are cleared whenever chip select is inactive.
module spi_cs_frame
    import spi_cs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  spi_evt_t  evt_i,
    output logic      cmd_end_o,
    output logic      frame_end_o,
    output logic      ans_load_o
);
    localparam bit_cnt_t  LAST_BIT  = bit_cnt_t'(BYTE_W - 1);
    localparam byte_cnt_t DONE_BYTE = byte_cnt_t'(FRAME_BYTES);
    localparam byte_cnt_t LAST_BYTE = byte_cnt_t'(FRAME_BYTES - 1);
    localparam byte_cnt_t RESP_BYTE = byte_cnt_t'(1);

    bit_cnt_t  bit_q;
    byte_cnt_t byte_q;

    // Advance bit/byte position on each rising SCK edge inside a frame
    always_ff @(posedge clk) begin
        if (!rst_n || !evt_i.active) begin
            bit_q  <= '0;
            byte_q <= '0;
        end else if (evt_i.rise && byte_q != DONE_BYTE) begin
            if (bit_q == LAST_BIT) begin
                bit_q  <= '0;
                byte_q <= byte_q + 1'b1;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // Decode frame boundaries from the current position
    always_comb begin
        cmd_end_o   = evt_i.rise && byte_q == '0 && bit_q == LAST_BIT;
        frame_end_o = evt_i.rise && byte_q == LAST_BYTE && bit_q == LAST_BIT;
        ans_load_o  = evt_i.fall && byte_q == RESP_BYTE && bit_q == '0;
    end

    assert_byte_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_q <= DONE_BYTE);
    assert_idle_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_i.active |=> (bit_q == '0 && byte_q == '0));
    assert_cmd_before_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |-> byte_q != '0);
endmodule

// File: rtl/spi_cs_shift.sv
`timescale 1ns/1ps
// Module: spi_cs_shift
// Holds the receive shift register, the captured command and the
// transmit shift register. Transmit starts each frame with the filler
// byte, loads the answer word at the first falling edge of byte 2 and
// shifts on every falling edge. Assumes position flags from spi_cs_frame.
module spi_cs_shift
    import spi_cs_pkg::*;
#(
    parameter logic [BYTE_W-1:0] DUMMY_BYTE = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  spi_evt_t          evt_i,
    input  logic              cmd_end_i,
    input  logic              ans_load_i,
    input  logic [RESP_W-1:0] ans_i,
    output logic [BYTE_W-1:0] cmd_o,
    output logic              miso_o
);
    localparam logic [RESP_W-1:0] IDLE_TX = {DUMMY_BYTE, {(RESP_W-BYTE_W){1'b0}}};

    logic [BYTE_W-1:0] rx_q;
    logic [BYTE_W-1:0] cmd_q;
    logic [RESP_W-1:0] tx_q;

    // Collect MOSI bits on rising edges; cleared outside a frame
    always_ff @(posedge clk) begin
        if (!rst_n || !evt_i.active) rx_q <= '0;
        else if (evt_i.rise)         rx_q <= {rx_q[BYTE_W-2:0], evt_i.mosi};
    end

    // Latch the full command byte at the command boundary
    always_ff @(posedge clk) begin
        if (!rst_n)         cmd_q <= '0;
        else if (cmd_end_i) cmd_q <= {rx_q[BYTE_W-2:0], evt_i.mosi};
    end

    // Transmit: filler when idle, answer load, shift on falling edges
    always_ff @(posedge clk) begin
        if (!rst_n || !evt_i.active) tx_q <= IDLE_TX;
        else if (ans_load_i)         tx_q <= ans_i;
        else if (evt_i.fall)         tx_q <= {tx_q[RESP_W-2:0], 1'b0};
    end

    assign cmd_o  = cmd_q;
    assign miso_o = evt_i.active & tx_q[RESP_W-1];

    assert_answer_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ans_load_i |=> tx_q == $past(ans_i));
    assert_filler_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_i.active) |-> tx_q == IDLE_TX);
    assert_hold_between_edges_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i.active && $past(evt_i.active) && !$past(evt_i.fall) && !$past(ans_load_i))
        |-> $stable(tx_q));
endmodule

// File: rtl/spi_cmd_slave.sv
`timescale 1ns/1ps
// Module: spi_cmd_slave
// Top of the SPI command-response slave: synchronizer, frame counter,
// shift registers and the registered strobes. Assumes an external
// combinational answer lookup driven from lut_cmd_o.
module spi_cmd_slave
    import spi_cs_pkg::*;
#(
    parameter int unsigned       SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] DUMMY_BYTE  = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              mosi_i,
    input  logic              cs_n_i,
    output logic              miso_o,
    output logic [BYTE_W-1:0] lut_cmd_o,
    input  logic [RESP_W-1:0] lut_data_i,
    output logic              cmd_valid_o,
    output logic [BYTE_W-1:0] cmd_o,
    output logic              frame_done_o
);
    spi_evt_t          evt;
    logic              cmd_end;
    logic              frame_end;
    logic              ans_load;
    logic [BYTE_W-1:0] cmd_byte;
    logic              cmd_valid_q;
    logic              done_q;

    spi_cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_i  (sck_i),
        .mosi_i (mosi_i),
        .cs_n_i (cs_n_i),
        .evt_o  (evt)
    );

    spi_cs_frame u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .cmd_end_o   (cmd_end),
        .frame_end_o (frame_end),
        .ans_load_o  (ans_load)
    );

    spi_cs_shift #(.DUMMY_BYTE(DUMMY_BYTE)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .cmd_end_i  (cmd_end),
        .ans_load_i (ans_load),
        .ans_i      (lut_data_i),
        .cmd_o      (cmd_byte),
        .miso_o     (miso_o)
    );

    // Register the boundary flags into single-cycle strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid_q <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            cmd_valid_q <= cmd_end;
            done_q      <= frame_end;
        end
    end

    assign cmd_valid_o  = cmd_valid_q;
    assign frame_done_o = done_q;
    assign cmd_o        = cmd_byte;
    assign lut_cmd_o    = cmd_byte;

    assert_cmd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o);
    assert_idle_miso_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> !miso_o);
endmodule

// File: tb/spi_cmd_slave_tb.sv
`timescale 1ns/1ps
// Directed bench for spi_cmd_slave: a bit-level mode-0 master model
// and a behavioural answer table.
module spi_cmd_slave_tb;
    localparam int HALF = 8;   // system clocks per SCK half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        mosi = 1'b0;
    logic        cs_n = 1'b1;
    logic        miso;
    logic [7:0]  lut_cmd;
    logic [31:0] lut_data;
    logic        cmd_valid;
    logic [7:0]  cmd_out;
    logic        frame_done;

    int errs = 0;
    int checks = 0;
    int cmd_cnt = 0;
    int done_cnt = 0;
    logic [7:0] last_cmd = 8'h00;
    logic [7:0] lut_seen = 8'h00;
    logic       idle_miso = 1'b0;
    logic       cap [64];

    always #2.5 clk = ~clk;

    function automatic logic [31:0] answer_of(input logic [7:0] c);
        if (c == 8'h01) return 32'h410547AF;
        return {c, ~c, c ^ 8'h3C, c + 8'h07};
    endfunction

    assign lut_data = answer_of(lut_cmd);

    spi_cmd_slave u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sck_i        (sck),
        .mosi_i       (mosi),
        .cs_n_i       (cs_n),
        .miso_o       (miso),
        .lut_cmd_o    (lut_cmd),
        .lut_data_i   (lut_data),
        .cmd_valid_o  (cmd_valid),
        .cmd_o        (cmd_out),
        .frame_done_o (frame_done)
    );

    // Count strobes away from the active edge
    always @(negedge clk) begin
        if (cmd_valid) begin
            cmd_cnt  = cmd_cnt + 1;
            last_cmd = cmd_out;
        end
        if (frame_done) done_cnt = done_cnt + 1;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_at(input int k);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) r[7-b] = cap[8*k+b];
        return r;
    endfunction

    function automatic logic [31:0] answer_seen();
        return {byte_at(1), byte_at(2), byte_at(3), byte_at(4)};
    endfunction

    // Master model: mode 0, MISO sampled just before each rising edge
    task automatic run_frame(input logic [7:0] cmd, input logic [31:0] tail, input int nbits);
        logic [39:0] word;
        word = {cmd, tail};
        for (int i = 0; i < 64; i++) cap[i] = 1'b0;
        cmd_cnt  = 0;
        done_cnt = 0;
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 40) ? word[39-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            cap[i] = miso;
            if (i == 8) lut_seen = lut_cmd;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        idle_miso = miso;
        repeat (6) @(negedge clk);
    endtask

    task automatic test_reset();
        repeat (4) @(negedge clk);
        chk("R1 miso in reset", miso, 0);
        chk("R7 cmd_valid in reset", cmd_valid, 0);
        chk("R8 frame_done in reset", frame_done, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 miso idle after reset", miso, 0);
    endtask

    task automatic test_basic();
        run_frame(8'h01, 32'h0, 40);
        chk("R2 filler byte", byte_at(0), 8'hA5);
        chk("R3 byte2", byte_at(1), 8'h41);
        chk("R3 byte3", byte_at(2), 8'h05);
        chk("R3 byte4", byte_at(3), 8'h47);
        chk("R3 byte5", byte_at(4), 8'hAF);
        chk("R4 lookup command", lut_seen, 8'h01);
        chk("R7 one cmd strobe", cmd_cnt, 1);
        chk("R7 cmd value", last_cmd, 8'h01);
        chk("R8 one done strobe", done_cnt, 1);
        chk("R1 miso after frame", idle_miso, 0);
    endtask

    task automatic test_back_to_back();
        logic [7:0] cmds [3];
        cmds = '{8'h10, 8'h22, 8'hFE};
        for (int k = 0; k < 3; k++) begin
            run_frame(cmds[k], 32'hDEADBEEF, 40);
            chk("R5 filler repeats", byte_at(0), 8'hA5);
            chk("R5 aligned answer", answer_seen(), answer_of(cmds[k]));
            chk("R4 lookup command", lut_seen, cmds[k]);
            chk("R8 done per frame", done_cnt, 1);
        end
    endtask

    task automatic test_abort();
        run_frame(8'h33, 32'h0, 20);
        chk("R6 no done on short frame", done_cnt, 0);
        chk("R7 cmd seen in short frame", cmd_cnt, 1);
        chk("R1 miso after abort", idle_miso, 0);
        run_frame(8'h44, 32'h0, 40);
        chk("R5 filler after abort", byte_at(0), 8'hA5);
        chk("R5 answer after abort", answer_seen(), answer_of(8'h44));
        run_frame(8'h55, 32'h0, 5);
        chk("R6 no strobes on tiny frame", cmd_cnt + done_cnt, 0);
        run_frame(8'h01, 32'h0, 40);
        chk("R5 answer after tiny frame", answer_seen(), 32'h410547AF);
    endtask

    task automatic test_mosi_ignored();
        run_frame(8'h01, 32'hFFFFFFFF, 40);
        chk("R9 answer with MOSI ones", answer_seen(), 32'h410547AF);
        run_frame(8'h01, 32'h5A5A1234, 40);
        chk("R9 answer with MOSI pattern", answer_seen(), 32'h410547AF);
        chk("R7 cmd unaffected by tail", last_cmd, 8'h01);
    endtask

    task automatic test_overrun();
        run_frame(8'h7C, 32'h0, 48);
        chk("R10 answer before overrun", answer_seen(), answer_of(8'h7C));
        chk("R10 extra bits zero", byte_at(5), 8'h00);
        chk("R10 single done", done_cnt, 1);
        chk("R10 single cmd", cmd_cnt, 1);
        run_frame(8'h02, 32'h0, 40);
        chk("R5 after overrun", answer_seen(), answer_of(8'h02));
    endtask

    initial begin
        test_reset();
        test_basic();
        test_back_to_back();
        test_abort();
        test_mosi_ignored();
        test_overrun();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule